// File: doc/BRIEF.md
# Two-Wire EEPROM Boot Loader

This block fills a small configuration register file from a serial EEPROM each time the chip comes out of reset. It waits until the flash loader reports that it has finished. It then runs one fixed read transaction on a two-wire bus, using a clock line and an open-drain data line. The transaction addresses device code 1010 with chip select 000 and sets the word pointer to offset 00h. A repeated START follows, and the block then reads a parameterised number of bytes in sequence. The bus clock is divided down from the system clock. Each bit occupies four equal quarter periods, and the clock is high during the middle two.

During the whole transaction the block holds a retry request. The host-facing target logic uses it to answer every access with a retry, so no host reads half-loaded configuration. If the EEPROM does not acknowledge, the block gives up: it sends a STOP, drops the retry request and leaves the register file at its reset defaults. The load runs once per reset.

Top module: `eeprom_boot_loader`

## Requirements
- R1: After reset, `scl_o` is 1, `sda_oe_o` is 0, `retry_req` is 0 and every register-file byte holds `DEFAULT_VAL`. This state holds until `flash_done` is sampled high.
- R2: `retry_req` rises in the cycle after `flash_done` is first sampled high. It stays high until the last quarter of the STOP bit ends, and then stays low.
- R3: The transaction starts with a START (data falls while the clock is high). It then sends 0xA0, releases the line for an acknowledge, sends 0x00, releases for an acknowledge, issues a repeated START, sends 0xA1 and releases for an acknowledge. All bytes go MSB first.
- R4: Every bit lasts 4×`DIV` system clocks. The clock is low in quarters 0 and 3 and high in quarters 1 and 2. Outside START and STOP, `sda_oe_o` changes only while the clock is low.
- R5: `NBYTES` bytes are read MSB first. The line is sampled at the end of quarter 1. The byte read from EEPROM offset i is written into register entry i, which appears at `cfg_regs[8*i+7:8*i]`.
- R6: After each received byte except the last, the master drives an acknowledge (`sda_oe_o`=1). After the last byte it leaves the line released (NACK).
- R7: The transaction ends with a STOP bit. The data line is driven in quarters 0 and 1 and released in quarters 2 and 3, while the clock is high in quarters 1 to 3. Afterwards the bus stays idle (clock high, data released).
- R8: If the acknowledge after the control byte is high, a STOP bit follows at once. Then `retry_req` falls and the register file keeps its defaults. A missing acknowledge after the address byte or the read control byte is handled the same way.
- R9: Once the load has finished, further activity on `flash_done` has no effect until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flash_done | input | 1 | Flash load finished; starts the EEPROM load |
| sda_i | input | 1 | Level of the data line as seen at the pin |
| scl_o | output | 1 | Bus clock level |
| sda_oe_o | output | 1 | 1 pulls the data line low, 0 releases it |
| retry_req | output | 1 | Host accesses must be retried while high |
| cfg_regs | output | 8*NBYTES | Loaded register file, entry i in bits 8i+7..8i |

## Verification
The hardest case to reach from the ports is the exchange where control of the data line passes between master and slave. This happens in acknowledge slots, in read bits and in the master acknowledge after the final byte, and every one of these depends on a slave that follows the bus bit by bit. The bench contains a behavioural EEPROM that decodes START, STOP and the address bytes from the pins, answers with acknowledges and streams its memory from the pointer. It can also be left silent to force the missing-device path. Meanwhile a slot-by-slot reference schedule gives the expected clock, drive and retry levels for every system clock.

// File: rtl/eepld_pkg.sv
package eepld_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_START1,
        ST_CTLW,
        ST_ACK1,
        ST_ADDR,
        ST_ACK2,
        ST_START2,
        ST_CTLR,
        ST_ACK3,
        ST_RX,
        ST_MACK,
        ST_STOP,
        ST_DONE
    } ld_state_e;

    localparam logic [7:0] CTRL_WR   = 8'hA0;
    localparam logic [7:0] CTRL_RD   = 8'hA1;
    localparam logic [7:0] START_OFS = 8'h00;

endpackage

// File: rtl/eepld_qtick.sv
module eepld_qtick #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic tick_o
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] CMAX = CW'(DIV - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        tick_o = en && (cnt_q == CMAX);
        if (!en || tick_o) cnt_d = '0;
        else               cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    generate
        if (DIV > 1) begin : g_chk
            AST_TICK_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
                tick_o |=> !tick_o); // R4
        end
    endgenerate

endmodule

// File: rtl/eepld_regfile.sv
module eepld_regfile #(
    parameter int         NBYTES      = 16,
    parameter int         IDXW        = 4,
    parameter logic [7:0] DEFAULT_VAL = 8'hFF
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  we,
    input  logic [IDXW-1:0]       waddr,
    input  logic [7:0]            wdata,
    output logic [8*NBYTES-1:0]   regs_flat
);
    logic [7:0] mem_d [NBYTES];
    logic [7:0] mem_q [NBYTES];

    always_comb begin
        for (int i = 0; i < NBYTES; i++) begin
            mem_d[i] = (we && waddr == IDXW'(i)) ? wdata : mem_q[i];
        end
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < NBYTES; i++) begin
            if (!rst_n) mem_q[i] <= DEFAULT_VAL;
            else        mem_q[i] <= mem_d[i];
        end
    end

    generate
        for (genvar g = 0; g < NBYTES; g++) begin : g_out
            assign regs_flat[8*g +: 8] = mem_q[g];
        end
    endgenerate

endmodule

// File: rtl/eeprom_boot_loader.sv
module eeprom_boot_loader
    import eepld_pkg::*;
#(
    parameter int         NBYTES      = 16,
    parameter int         DIV         = 4,
    parameter logic [7:0] DEFAULT_VAL = 8'hFF
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  flash_done,
    input  logic                  sda_i,
    output logic                  scl_o,
    output logic                  sda_oe_o,
    output logic                  retry_req,
    output logic [8*NBYTES-1:0]   cfg_regs
);
    localparam int IDXW = (NBYTES > 1) ? $clog2(NBYTES) : 1;
    localparam logic [IDXW-1:0] LAST_IDX = IDXW'(NBYTES - 1);

    typedef struct packed {
        ld_state_e       st;
        logic [1:0]      ph;
        logic [2:0]      bitn;
        logic [7:0]      sh;
        logic [IDXW-1:0] idx;
        logic            nack;
    } ctl_t;

    ctl_t r_d, r_q;
    logic busy, tick, slot_end, wr_en;

    assign busy     = (r_q.st != ST_IDLE) && (r_q.st != ST_DONE);
    assign slot_end = tick && (r_q.ph == 2'd3);
    assign wr_en    = (r_q.st == ST_RX) && (r_q.bitn == 3'd7) && slot_end;

    eepld_qtick #(.DIV(DIV)) u_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .en     (busy),
        .tick_o (tick)
    );

    eepld_regfile #(.NBYTES(NBYTES), .IDXW(IDXW), .DEFAULT_VAL(DEFAULT_VAL)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .we        (wr_en),
        .waddr     (r_q.idx),
        .wdata     (r_q.sh),
        .regs_flat (cfg_regs)
    );

    // Next-state computation for the whole sequencer
    always_comb begin
        r_d = r_q;
        if (r_q.st == ST_IDLE) begin
            if (flash_done) begin
                r_d.st   = ST_START1;
                r_d.ph   = 2'd0;
                r_d.bitn = 3'd0;
                r_d.idx  = '0;
                r_d.nack = 1'b0;
            end
        end else if (busy && tick) begin
            r_d.ph = r_q.ph + 2'd1;
            if (r_q.ph == 2'd1) begin
                if (r_q.st inside {ST_ACK1, ST_ACK2, ST_ACK3}) r_d.nack = sda_i;
                if (r_q.st == ST_RX) r_d.sh = {r_q.sh[6:0], sda_i};
            end
            if (r_q.ph == 2'd3) begin
                case (r_q.st)
                    ST_START1: begin
                        r_d.st = ST_CTLW; r_d.sh = CTRL_WR; r_d.bitn = 3'd0;
                    end
                    ST_CTLW, ST_ADDR, ST_CTLR: begin
                        if (r_q.bitn == 3'd7) begin
                            r_d.bitn = 3'd0;
                            r_d.st   = (r_q.st == ST_CTLW) ? ST_ACK1 :
                                       (r_q.st == ST_ADDR) ? ST_ACK2 : ST_ACK3;
                        end else begin
                            r_d.bitn = r_q.bitn + 3'd1;
                            r_d.sh   = {r_q.sh[6:0], 1'b0};
                        end
                    end
                    ST_ACK1: begin
                        r_d.st = r_q.nack ? ST_STOP : ST_ADDR;
                        r_d.sh = START_OFS;
                    end
                    ST_ACK2:   r_d.st = r_q.nack ? ST_STOP : ST_START2;
                    ST_START2: begin
                        r_d.st = ST_CTLR; r_d.sh = CTRL_RD; r_d.bitn = 3'd0;
                    end
                    ST_ACK3: begin
                        r_d.st = r_q.nack ? ST_STOP : ST_RX; r_d.bitn = 3'd0;
                    end
                    ST_RX: begin
                        if (r_q.bitn == 3'd7) begin
                            r_d.st = ST_MACK; r_d.bitn = 3'd0;
                        end else begin
                            r_d.bitn = r_q.bitn + 3'd1;
                        end
                    end
                    ST_MACK: begin
                        if (r_q.idx == LAST_IDX) begin
                            r_d.st = ST_STOP;
                        end else begin
                            r_d.idx = r_q.idx + 1'b1;
                            r_d.st  = ST_RX;
                        end
                    end
                    ST_STOP: r_d.st = ST_DONE;
                    default: ;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '{st: ST_IDLE, default: '0};
        else        r_q <= r_d;
    end

    // Pin levels decoded from slot type and quarter
    always_comb begin
        scl_o    = 1'b1;
        sda_oe_o = 1'b0;
        case (r_q.st)
            ST_START1, ST_START2: begin
                scl_o    = (r_q.ph == 2'd1) || (r_q.ph == 2'd2);
                sda_oe_o = r_q.ph[1];
            end
            ST_STOP: begin
                scl_o    = (r_q.ph != 2'd0);
                sda_oe_o = !r_q.ph[1];
            end
            ST_CTLW, ST_ADDR, ST_CTLR: begin
                scl_o    = (r_q.ph == 2'd1) || (r_q.ph == 2'd2);
                sda_oe_o = !r_q.sh[7];
            end
            ST_ACK1, ST_ACK2, ST_ACK3, ST_RX: begin
                scl_o    = (r_q.ph == 2'd1) || (r_q.ph == 2'd2);
                sda_oe_o = 1'b0;
            end
            ST_MACK: begin
                scl_o    = (r_q.ph == 2'd1) || (r_q.ph == 2'd2);
                sda_oe_o = (r_q.idx != LAST_IDX);
            end
            default: ;
        endcase
    end

    assign retry_req = busy;

    AST_START_ONLY_IN_START: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(sda_oe_o) && scl_o && $past(scl_o)) |-> (r_q.st inside {ST_START1, ST_START2})); // R3
    AST_STOP_ONLY_IN_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(sda_oe_o) && scl_o && $past(scl_o)) |-> (r_q.st == ST_STOP)); // R7
    AST_RETRY_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(retry_req) |-> $past(flash_done)); // R2
    AST_RETRY_FALL_IDLE_BUS: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(retry_req) |-> (scl_o && !sda_oe_o)); // R7
    AST_WRITE_WHILE_RETRY: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> retry_req); // R5
    AST_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(r_q.st) == ST_DONE) |-> (r_q.st == ST_DONE)); // R9

endmodule

// File: tb/eeprom_boot_loader_test.sv
module eeprom_boot_loader_test;
    localparam int         NB   = 16;
    localparam int         QDIV = 4;
    localparam logic [7:0] DFLT = 8'hFF;
    localparam int K_START = 0, K_DRV = 1, K_REL = 2, K_STOP = 3;

    typedef struct {int kind; int val; int tag;} slot_t;

    logic clk, rst_n, flash_done, sda_line, scl_o, sda_oe_o, retry_req;
    logic [8*NB-1:0] cfg_regs;

    int vectors = 0, fails = 0;
    bit finished = 0;

    slot_t q[$];
    int    post_tag;
    logic [7:0] mem [256];
    bit   slv_present;
    logic slv_drv;

    assign sda_line = !(sda_oe_o || slv_drv);

    eeprom_boot_loader #(.NBYTES(NB), .DIV(QDIV), .DEFAULT_VAL(DFLT)) uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .flash_done (flash_done),
        .sda_i      (sda_line),
        .scl_o      (scl_o),
        .sda_oe_o   (sda_oe_o),
        .retry_req  (retry_req),
        .cfg_regs   (cfg_regs)
    );

    initial begin
        clk = 0;
        forever #5 clk = ~clk;
    end

    // Reference schedule: slot index and quarter per system clock
    bit mstarted;
    int cyc;
    always @(posedge clk) begin
        if (!rst_n) begin
            mstarted <= 0; cyc <= 0;
        end else if (!mstarted && flash_done) begin
            mstarted <= 1; cyc <= 0;
        end else if (mstarted) begin
            cyc <= cyc + 1;
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            logic es, eo, er;
            int tag, slot, ph;
            es = 1; eo = 0; er = 0; tag = 1;   // R1 idle bus before start
            if (mstarted) begin
                slot = cyc / (4*QDIV);
                ph   = (cyc % (4*QDIV)) / QDIV;
                if (slot < q.size()) begin
                    er  = 1;
                    tag = q[slot].tag;
                    case (q[slot].kind)
                        K_START: begin es = (ph == 1 || ph == 2); eo = (ph >= 2); end
                        K_DRV:   begin es = (ph == 1 || ph == 2); eo = !q[slot].val[0]; end
                        K_REL:   begin es = (ph == 1 || ph == 2); eo = 0; end
                        default: begin es = (ph >= 1); eo = (ph <= 1); end
                    endcase
                end else begin
                    tag = post_tag;  // R9 or R8 after completion
                end
            end
            vectors++;
            if (retry_req !== er) begin
                fails++;
                $display("FAIL R2 cycle %0d: retry_req actual %b expected %b", cyc, retry_req, er);
            end else if (scl_o !== es || sda_oe_o !== eo) begin
                fails++;
                $display("FAIL R%0d cycle %0d: scl/oe actual %b%b expected %b%b",
                         tag, cyc, scl_o, sda_oe_o, es, eo);
            end
        end
    end

    // Behavioural EEPROM slave
    typedef enum int {SL_IDLE, SL_WR, SL_ACK, SL_RD, SL_MACK} sl_e;
    sl_e sl;
    logic scl_p, sda_p, mack, rd;
    int bitn, nbytes;
    logic [7:0] sh, ptr;
    always @(negedge clk) begin
        if (!rst_n) begin
            sl = SL_IDLE; slv_drv = 0; scl_p = 1; sda_p = 1; ptr = 0; rd = 0;
            bitn = 0; nbytes = 0; sh = 0; mack = 0;
        end else begin
            if (scl_o && scl_p && sda_p && !sda_line) begin
                sl = SL_WR; bitn = 0; nbytes = 0; slv_drv = 0;
            end else if (scl_o && scl_p && !sda_p && sda_line) begin
                sl = SL_IDLE; slv_drv = 0;
            end else if (scl_o && !scl_p) begin
                if (sl == SL_WR) begin sh = {sh[6:0], sda_line}; bitn++; end
                else if (sl == SL_RD) bitn++;
                else if (sl == SL_MACK) mack = !sda_line;
            end else if (!scl_o && scl_p) begin
                case (sl)
                    SL_WR: if (bitn == 8) begin
                        sl = SL_ACK; slv_drv = slv_present;
                        if (nbytes == 0) rd = sh[0];
                        else ptr = sh;
                        nbytes++;
                    end
                    SL_ACK: begin
                        bitn = 0;
                        if (rd && slv_present) begin sl = SL_RD; slv_drv = !mem[ptr][7]; end
                        else begin sl = SL_WR; slv_drv = 0; end
                    end
                    SL_RD: if (bitn == 8) begin sl = SL_MACK; slv_drv = 0; end
                           else slv_drv = !mem[ptr][7-bitn];
                    SL_MACK: begin
                        ptr++; bitn = 0;
                        if (mack) begin sl = SL_RD; slv_drv = !mem[ptr][7]; end
                        else begin sl = SL_IDLE; slv_drv = 0; end
                    end
                    default: ;
                endcase
            end
            scl_p = scl_o; sda_p = sda_line;
        end
    end

    function automatic void push(int kind, int val, int tag);
        slot_t s;
        s.kind = kind; s.val = val; s.tag = tag;
        q.push_back(s);
    endfunction

    function automatic void push_byte(logic [7:0] b, int tag);
        for (int i = 7; i >= 0; i--) push(K_DRV, int'(b[i]), tag);
    endfunction

    task automatic check_regs(bit loaded, int tag);
        for (int i = 0; i < NB; i++) begin
            logic [7:0] exp;
            exp = loaded ? mem[i] : DFLT;
            vectors++;
            if (cfg_regs[8*i +: 8] !== exp) begin
                fails++;
                $display("FAIL R%0d entry %0d: actual %h expected %h", tag, i, cfg_regs[8*i +: 8], exp);
            end
        end
    endtask

    task automatic run(bit present, int seed);
        rst_n = 0; flash_done = 0; slv_present = present;
        for (int i = 0; i < 256; i++)
            mem[i] = (seed == 1) ? 8'((i*73 + 29) ^ (i << 4)) : ((i % 2 == 0) ? 8'h80 : 8'h7F);
        q.delete();
        push(K_START, 0, 3);                          // R3 first START
        push_byte(8'hA0, 3);
        push(K_REL, 0, 3);
        if (!present) begin
            push(K_STOP, 0, 8);                       // R8 abort after missing acknowledge
            post_tag = 8;
        end else begin
            push_byte(8'h00, 3);
            push(K_REL, 0, 3);
            push(K_START, 0, 3);
            push_byte(8'hA1, 3);
            push(K_REL, 0, 3);
            for (int b = 0; b < NB; b++) begin
                for (int k = 0; k < 8; k++) push(K_REL, 0, 5);   // R5 read bits
                push(K_DRV, (b == NB-1) ? 1 : 0, 6);             // R6 ack / final NACK
            end
            push(K_STOP, 0, 7);                       // R7
            post_tag = 9;
        end
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        @(negedge clk);
        check_regs(0, 1);                             // R1 defaults after reset
        repeat (6) @(posedge clk);
        #1 flash_done = 1;
        repeat (q.size()*4*QDIV + 8) @(posedge clk);
        #1;
        for (int k = 0; k < 40; k++) begin            // R9 no restart
            flash_done = (k % 2 == 1);
            @(posedge clk); #1;
        end
        @(negedge clk);
        check_regs(present, present ? 5 : 8);         // R5 loaded data, R8 defaults kept
    endtask

    initial begin
        rst_n = 0; flash_done = 0; slv_present = 0;
        run(0, 0);
        run(1, 1);
        run(1, 2);
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

endmodule